// File: doc/BRIEF.md
# Calibrated Seconds Tick Prescaler

This block divides a slow crystal clock of roughly 33.33 kHz down to one strobe per second. A calibration word sets the divide. Its low field gives the whole number of crystal cycles in a second. A small fractional field, used only while its enable bit is set, feeds an accumulator. Each time the accumulator carries, the following second is one crystal cycle longer. Over many seconds this brings the average rate into line with a crystal that does not divide to an integer.

The block also makes its running sub-second count readable. It takes a time-load strobe from the register logic that sits around it. Software raises that strobe when it writes a new time, and the current second then starts over. A new calibration word is held in a pending register. It enters service at the next second boundary or at the next time load. The bus interface, the seconds counter and the interrupt logic are outside this block.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tick_count` is 0 and `sec_pulse` is low. The reset calibration (parameter `RESET_CAL`) is in force, so the first pulse comes N+1 cycles after reset is released, plus no stretch, where N is its integer field.
- R2: The calibration word is CAL_W = INT_W+FRAC_W+1 bits wide. Bits [INT_W-1:0] hold the integer limit N. Bits [INT_W+FRAC_W-1:INT_W] hold the fraction f. Bit [CAL_W-1] enables fractional correction. The default 0x198233 decodes as N = 0x8233, f = 9, enabled.
- R3: `tick_count` rises by one each cycle from 0 to N. On the next edge it wraps to 0, and `sec_pulse` is high for that one cycle, in which `tick_count` reads 0.
- R4: With correction enabled, each second boundary adds f to a FRAC_W-bit accumulator. A carry out makes the next second one cycle longer, with `tick_count` holding at N for the extra cycle. After a time load, pulse K arrives K*(N+1) + floor((K-1)*f / 2^FRAC_W) cycles after the load edge.
- R5: With the enable bit clear, the fraction field has no effect, and every second lasts exactly N+1 cycles.
- R6: A `time_load` edge clears `tick_count` and the accumulator, cancels any pending stretch and suppresses the pulse. It also puts the pending calibration into service, so the first pulse comes N+1 cycles after the load.
- R7: A calibration written in the middle of a second leaves the current second's length unchanged. The new value governs every second after the next boundary.
- R8: `tick_count` never exceeds the active limit N, and between wraps it advances by exactly one per cycle, except during the single stretch cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_wr | input | 1 | Write strobe for the pending calibration |
| cal_data | input | CAL_W | Calibration word: enable, fraction, integer limit |
| time_load | input | 1 | Restarts the sub-second count when a new time is written |
| tick_count | output | INT_W | Live sub-second tick count |
| sec_pulse | output | 1 | One-cycle strobe at each second boundary |

## Verification
The bench builds the block with INT_W = 3 and FRAC_W = 2, and a reset calibration of N = 3, f = 3, enabled. This size makes it possible to sweep every integer limit, every fraction and both enable settings, and the sweep includes the degenerate limit N = 0, where every cycle is a boundary. For each setting the bench times six seconds after a load and compares each pulse with the closed-form cumulative count, which covers accumulator carries at every phase. Separate cases check the reset period and a calibration change made in the middle of a second.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  parameter int DEF_INT_W  = 16;
  parameter int DEF_FRAC_W = 4;
  parameter logic [31:0] DEF_CAL = 32'h0019_8233;
endpackage

// File: rtl/rtc_cal_shadow.sv
module rtc_cal_shadow #(
  parameter int CAL_W = 21,
  parameter int ACT_W = 16,
  parameter logic [CAL_W-1:0] RST_CAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CAL_W-1:0] wr_cal,
  input  logic             adopt,
  output logic [CAL_W-1:0] next_cal,
  output logic [ACT_W-1:0] active_lim
);
  logic [CAL_W-1:0] pending;

  always_comb next_cal = wr_en ? wr_cal : pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= RST_CAL;
      active_lim <= RST_CAL[ACT_W-1:0];
    end else begin
      pending <= next_cal;
      if (adopt) active_lim <= next_cal[ACT_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              boundary,
  input  logic              en,
  input  logic [FRAC_W-1:0] frac,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  always_comb sum = {1'b0, acc} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc     <= '0;
      stretch <= 1'b0;
    end else if (boundary) begin
      if (en) begin
        acc     <= sum[FRAC_W-1:0];
        stretch <= sum[FRAC_W];
      end else begin
        stretch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] limit,
  input  logic             stretch,
  output logic [INT_W-1:0] count,
  output logic             pulse,
  output logic             boundary,
  output logic             hold
);
  logic at_top;

  always_comb begin
    at_top   = (count == limit);
    boundary = !load && at_top && !(stretch && !hold);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      count <= '0;
      hold  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= boundary;
      if (boundary) begin
        count <= '0;
        hold  <= 1'b0;
      end else if (at_top) begin
        hold <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter logic [31:0] RESET_CAL = DEF_CAL,
  localparam int CAL_W = INT_W + FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_wr,
  input  logic [CAL_W-1:0] cal_data,
  input  logic             time_load,
  output logic [INT_W-1:0] tick_count,
  output logic             sec_pulse
);
  localparam logic [CAL_W-1:0] RST_CAL = RESET_CAL[CAL_W-1:0];

  logic [CAL_W-1:0]  next_cal;
  logic [INT_W-1:0]  act_int;
  logic              boundary;
  logic              stretch;
  logic              hold;
  logic              adopt;
  logic              next_en;
  logic [FRAC_W-1:0] next_frac;

  always_comb begin
    adopt     = time_load | boundary;
    next_en   = next_cal[CAL_W-1];
    next_frac = next_cal[CAL_W-2:INT_W];
  end

  rtc_cal_shadow #(.CAL_W(CAL_W), .ACT_W(INT_W), .RST_CAL(RST_CAL)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(cal_wr), .wr_cal(cal_data),
    .adopt(adopt), .next_cal(next_cal), .active_lim(act_int)
  );

  rtc_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .clear(time_load), .boundary(boundary),
    .en(next_en), .frac(next_frac), .stretch(stretch)
  );

  rtc_tick_counter #(.INT_W(INT_W)) u_count (
    .clk(clk), .rst(rst), .load(time_load), .limit(act_int),
    .stretch(stretch), .count(tick_count), .pulse(sec_pulse),
    .boundary(boundary), .hold(hold)
  );
endmodule

// File: rtl/rtc_tick_prescaler_chk.sv
module rtc_tick_prescaler_chk #(
  parameter int INT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             time_load,
  input logic [INT_W-1:0] tick_count,
  input logic             sec_pulse,
  input logic [INT_W-1:0] limit,
  input logic             boundary,
  input logic             hold
);
  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    time_load |=> (tick_count == '0 && !sec_pulse));

  // R3
  pulse_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> tick_count == '0);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!time_load && tick_count != limit) |=> tick_count == INT_W'($past(tick_count) + 1'b1));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    tick_count <= limit);

  // R7
  limit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(time_load || boundary) |=> $stable(limit));

  // R4
  hold_once_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !time_load) |=> !hold);
endmodule

bind rtc_tick_prescaler rtc_tick_prescaler_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .time_load(time_load), .tick_count(tick_count),
  .sec_pulse(sec_pulse), .limit(act_int), .boundary(boundary), .hold(hold)
);

// File: tb/rtc_tick_prescaler_test.sv
module rtc_tick_prescaler_test;
  localparam int PERIOD = 10;
  localparam int IW = 3;
  localparam int FW = 2;
  localparam int CW = IW + FW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cal_wr = 1'b0;
  logic [CW-1:0] cal_data = '0;
  logic          time_load = 1'b0;
  logic [IW-1:0] tick_count;
  logic          sec_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rtc_tick_prescaler #(.INT_W(IW), .FRAC_W(FW), .RESET_CAL(32'h3B)) uut (
    .clk(clk), .rst(rst), .cal_wr(cal_wr), .cal_data(cal_data),
    .time_load(time_load), .tick_count(tick_count), .sec_pulse(sec_pulse)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // steps until a pulse; returns the running cycle count
  task automatic wait_pulse(inout int c, input int lim, input string req);
    int g = 0;
    do begin
      step();
      c++;
      g++;
      checks++;
      if (tick_count > lim) begin
        fails++;
        $display("FAIL R8 actual=%0d expected<=%0d", tick_count, lim);
      end
    end while (!sec_pulse && g < 100);
    check({req, " pulse_zero R3"}, int'(tick_count), 0);
  endtask

  task automatic program_and_load(input logic [CW-1:0] w);
    cal_data = w;
    cal_wr = 1'b1;
    step();
    cal_wr = 1'b0;
    time_load = 1'b1;
    step();
    time_load = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    // R1: reset state and period of the reset calibration (N=3,f=3,en)
    step(); step(); step();
    check("R1 reset count", int'(tick_count), 0);
    check("R1 reset pulse", int'(sec_pulse), 0);
    rst = 1'b0;
    c = 0;
    check("R1 count after release", int'(tick_count), 0);
    for (int k = 1; k <= 4; k++) begin
      wait_pulse(c, 3, "R1");
      check("R1 R2 reset period", c, k * 4 + ((k - 1) * 3) / 4);
    end

    // R4 R5 R6: full sweep of limit, fraction and enable
    for (int n = 0; n < (1 << IW); n++)
      for (int f = 0; f < (1 << FW); f++)
        for (int e = 0; e < 2; e++) begin
          program_and_load({e[0], f[FW-1:0], n[IW-1:0]});
          check("R6 load clears", int'(tick_count), 0);
          c = 0;
          for (int k = 1; k <= 6; k++) begin
            wait_pulse(c, n, "R4");
            if (e == 1) check("R4 fractional timing", c, k * (n + 1) + ((k - 1) * f) / 4);
            else        check("R5 fraction ignored", c, k * (n + 1));
          end
        end

    // R7 R8: mid-second calibration change, N=5 then N=2
    program_and_load({1'b0, 2'b11, 3'd5});
    c = 0;
    step(); c++;
    check("R8 count step", int'(tick_count), 1);
    step(); c++;
    check("R8 count step", int'(tick_count), 2);
    cal_data = {1'b0, 2'b00, 3'd2};
    cal_wr = 1'b1;
    step(); c++;
    cal_wr = 1'b0;
    check("R7 current second kept", int'(tick_count), 3);
    wait_pulse(c, 5, "R7");
    check("R7 old length", c, 6);
    wait_pulse(c, 5, "R7");
    check("R7 new length", c, 9);
    wait_pulse(c, 5, "R7");
    check("R7 new length", c, 12);

    // R6: load mid-second restarts the period
    step(); step();
    time_load = 1'b1;
    step();
    time_load = 1'b0;
    check("R6 load pulse suppressed", int'(sec_pulse), 0);
    c = 0;
    wait_pulse(c, 2, "R6");
    check("R6 first period after load", c, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule